// File: doc/BRIEF.md
# DS3 Receive Payload Output Stage

This block is the last stage on the receive side of a clear-channel DS3 framer. It takes the recovered serial bit stream, one bit per bit period, and tracks where each bit falls inside the 4760-bit frame. The frame is divided into 56 blocks of 85 bits. The leading bit of every block is overhead and the other 84 bits are payload. Each bit is passed out on a serial data pin together with a line clock.

A second output pin serves one of two roles, chosen by a mode input:

- **Serial mode:** the pin is a per-bit overhead flag. Downstream logic samples the data and the flag on the falling edge of the line clock, and keeps only the bits whose flag is low.
- **Gapped-clock mode:** the pin becomes a payload clock. It pulses once for each payload bit and stays low across overhead bits. Downstream logic simply samples the data on its rising edge.

The block runs from a clock at twice the bit rate, and every output comes straight from a flip-flop. A frame-sync input forces the current bit to be frame position 0. Two totals report how many payload bits and overhead bits were seen between consecutive frame starts.

Top module: `ds3_payload_out`

## Requirements
- R1: `line_clk` toggles on every `clk` edge after reset, so each bit period is two `clk` cycles. It rises on the edge that loads a new bit. `ser_out` changes only on that rising edge and holds steady through the low half.
- R2: Frame positions run from 0 to 4759 and then wrap to 0. A position is overhead exactly when it is a multiple of 85; this gives 56 overhead bits and 4704 payload bits per frame.
- R3: In serial mode (`gap_mode` = 0 in effect), `ind_out` is 1 for an overhead bit and 0 for a payload bit. It changes only when `line_clk` rises and holds for the whole bit period.
- R4: In gapped-clock mode (`gap_mode` = 1 in effect), `ind_out` is high in the high half of `line_clk` for payload bits only. It is low in every low half and across the whole period of an overhead bit.
- R5: `ser_out` equals the value of `ser_in` sampled on the `clk` edge that starts the bit period.
- R6: If `frame_sync` is 1 on a loading edge, the bit loaded on that edge takes position 0 and is treated as overhead. Counting continues from there.
- R7: `gap_mode` is sampled only on the loading edge of a position-0 bit. A change in the middle of a frame has no effect until the next frame start.
- R8: When a position-0 bit is loaded, `pay_total` and `oh_total` take the payload and overhead counts of all bits loaded since the previous position-0 bit. A complete frame gives 4704 and 56.
- R9: While `rst_n` is low, all outputs are 0 and the mode is serial. The first `clk` edge after release loads a bit, and that bit takes position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Recovered serial bit, sampled on loading edges |
| frame_sync | input | 1 | Forces the bit being loaded to frame position 0 |
| gap_mode | input | 1 | 0 selects serial mode, 1 selects gapped-clock mode; applied at frame start |
| line_clk | output | 1 | Line clock, one period per bit |
| ser_out | output | 1 | Serial data output |
| ind_out | output | 1 | Overhead flag (serial mode) or gapped payload clock (gapped mode) |
| pay_total | output | 13 | Payload bits counted in the previous frame interval |
| oh_total | output | 6 | Overhead bits counted in the previous frame interval |

## Verification
The assertions check the bit-period timing on every cycle. They cover the strict toggling of the line clock, data that holds through the low half, and a serial flag that holds through the low half. They also check that a gapped clock is never high while the line clock is low, and that the totals stay within their frame limits. The exact overhead positions, the bit-for-bit data path, the deferral of a mode change to the frame boundary, the effect of a resync on the latched totals, and placement after reset are only shown by the bench. It compares the outputs against its own frame-position model over whole frames.

// File: rtl/ds3_payload_out.sv
module ds3_payload_out #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 56,
  localparam int BW = $clog2(BLK_BITS),
  localparam int KW = $clog2(BLKS),
  localparam int PW = $clog2((BLK_BITS - 1) * BLKS + 1),
  localparam int OW = $clog2(BLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  input  logic          frame_sync,
  input  logic          gap_mode,
  output logic          line_clk,
  output logic          ser_out,
  output logic          ind_out,
  output logic [PW-1:0] pay_total,
  output logic [OW-1:0] oh_total
);

  logic          phase;
  logic [BW-1:0] bit_idx;
  logic [KW-1:0] blk_idx;
  logic          oh_q;
  logic          mode_q;
  logic [PW-1:0] pay_run;
  logic [OW-1:0] oh_run;

  wire           load     = !phase;
  wire           last_bit = bit_idx == BW'(BLK_BITS - 1);
  wire           last_blk = blk_idx == KW'(BLKS - 1);
  wire           start    = frame_sync | (last_bit & last_blk);
  wire  [BW-1:0] bit_nx   = (frame_sync | last_bit) ? '0 : bit_idx + 1'b1;
  wire  [KW-1:0] blk_nx   = start ? '0 : (last_bit ? blk_idx + 1'b1 : blk_idx);
  wire           oh_nx    = bit_nx == '0;
  wire           mode_nx  = start ? gap_mode : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      bit_idx   <= BW'(BLK_BITS - 1);
      blk_idx   <= KW'(BLKS - 1);
      oh_q      <= 1'b0;
      mode_q    <= 1'b0;
      line_clk  <= 1'b0;
      ser_out   <= 1'b0;
      ind_out   <= 1'b0;
      pay_run   <= '0;
      oh_run    <= '0;
      pay_total <= '0;
      oh_total  <= '0;
    end else begin
      phase    <= !phase;
      line_clk <= load;
      if (load) begin
        ser_out <= ser_in;
        bit_idx <= bit_nx;
        blk_idx <= blk_nx;
        oh_q    <= oh_nx;
        mode_q  <= mode_nx;
        ind_out <= mode_nx ? !oh_nx : oh_nx;
        if (start) begin
          pay_total <= pay_run;
          oh_total  <= oh_run;
          pay_run   <= '0;
          oh_run    <= OW'(1);
        end else begin
          pay_run <= pay_run + PW'(!oh_nx);
          oh_run  <= oh_run + OW'(oh_nx);
        end
      end else begin
        ind_out <= mode_q ? 1'b0 : oh_q;
      end
    end
  end

  assert_lclk_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_clk |=> line_clk);
  assert_lclk_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_clk |=> !line_clk);
  assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_clk |-> $stable(ser_out));
  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_clk && !mode_q) |-> $stable(ind_out));
  assert_gap_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !line_clk) |-> !ind_out);
  assert_gap_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && ind_out) |-> line_clk);
  assert_total_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_total <= OW'(BLKS)) && (pay_total <= PW'((BLK_BITS - 1) * BLKS)));

endmodule

// File: tb/sim_ds3_payload_out.sv
module sim_ds3_payload_out;
  localparam int BLK   = 85;
  localparam int FRAME = 4760;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, frame_sync = 1'b0, gap_mode = 1'b0;
  logic line_clk, ser_out, ind_out;
  logic [12:0] pay_total;
  logic [5:0]  oh_total;

  ds3_payload_out u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .frame_sync(frame_sync),
    .gap_mode(gap_mode), .line_clk(line_clk), .ser_out(ser_out),
    .ind_out(ind_out), .pay_total(pay_total), .oh_total(oh_total)
  );

  always #10 clk = !clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_pos = FRAME - 1;
  bit m_mode = 0;
  int r_pay = 0, r_oh = 0, e_pay = 0, e_oh = 0;
  int err_lclk = 0, err_data = 0, err_ind = 0, err_tot = 0;
  logic [14:0] lfsr = 15'h1ace;

  // stimulus table: {gap_mode, pattern[1:0]}; 0 lfsr, 1 ones, 2 alternating, 3 zeros
  localparam logic [2:0] VEC [4] = '{3'b0_00, 3'b1_00, 3'b0_10, 3'b1_01};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_errs();
    err_lclk = 0; err_data = 0; err_ind = 0; err_tot = 0;
  endtask

  task automatic model_reset();
    m_pos = FRAME - 1; m_mode = 0; r_pay = 0; r_oh = 0; e_pay = 0; e_oh = 0;
  endtask

  task automatic send_bit(input logic b, input logic fs, input logic gm);
    int p;
    bit oh;
    @(negedge clk);
    ser_in = b; frame_sync = fs; gap_mode = gm;
    p = (fs || m_pos == FRAME - 1) ? 0 : m_pos + 1;
    oh = (p % BLK) == 0;
    if (p == 0) begin
      m_mode = gm; e_pay = r_pay; e_oh = r_oh; r_pay = 0; r_oh = 0;
    end
    if (oh) r_oh++; else r_pay++;
    m_pos = p;
    @(posedge clk); #2;
    if (line_clk !== 1'b1) err_lclk++;
    if (ser_out !== b) err_data++;
    if (ind_out !== (m_mode ? !oh : oh)) err_ind++;
    if (pay_total !== 13'(e_pay) || oh_total !== 6'(e_oh)) err_tot++;
    @(posedge clk); #2;
    if (line_clk !== 1'b0) err_lclk++;
    if (ser_out !== b) err_data++;
    if (ind_out !== (m_mode ? 1'b0 : oh)) err_ind++;
  endtask

  function automatic logic next_bit(input logic [1:0] pat, input int i);
    case (pat)
      2'd1: return 1'b1;
      2'd2: return i[0];
      2'd3: return 1'b0;
      default: begin
        lfsr = {lfsr[13:0], lfsr[14] ^ lfsr[13]};
        return lfsr[0];
      end
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check({line_clk, ser_out, ind_out} == 3'b000, "R9 reset outputs", int'({line_clk, ser_out, ind_out}), 0);
    check(pay_total == 0 && oh_total == 0, "R9 reset totals", int'(pay_total), 0);
    rst_n = 1'b1;

    // table walk: one full frame per entry
    foreach (VEC[k]) begin
      clear_errs();
      for (int i = 0; i < FRAME; i++) begin
        send_bit(next_bit(VEC[k][1:0], i), 1'b0, VEC[k][2]);
        if (i == 0 && k > 0) begin
          check(pay_total == 4704, "R8 payload total", int'(pay_total), 4704);
          check(oh_total == 56, "R2 overhead total", int'(oh_total), 56);
        end
      end
      check(err_lclk == 0, "R1 line clock shape", err_lclk, 0);
      check(err_data == 0, "R5 data path", err_data, 0);
      check(err_ind == 0, VEC[k][2] ? "R4 gapped clock" : "R3 overhead flag", err_ind, 0);
      check(err_tot == 0, "R8 totals vs model", err_tot, 0);
    end

    // R7: mode request mid-frame (serial in effect), gapped only after the boundary
    clear_errs();
    send_bit(1'b1, 1'b0, 1'b0);
    check(pay_total == 4704 && oh_total == 56, "R8 last table frame", int'(pay_total), 4704);
    for (int i = 1; i < FRAME; i++) send_bit(next_bit(2'd0, i), 1'b0, i > 300);
    check(err_ind == 0, "R7 mode held within frame", err_ind, 0);
    send_bit(1'b0, 1'b0, 1'b1);
    send_bit(1'b1, 1'b0, 1'b1);
    check(line_clk == 0 && ind_out == 0, "R4 low half gapped", int'(ind_out), 0);
    check(err_ind == 0, "R7 mode applied at boundary", err_ind, 0);

    // R6: resync after 1000 bits since frame start
    clear_errs();
    for (int i = 2; i < 1000; i++) send_bit(next_bit(2'd0, i), 1'b0, 1'b0);
    send_bit(1'b1, 1'b1, 1'b0);
    check(pay_total == 988, "R6 resync payload total", int'(pay_total), 988);
    check(oh_total == 12, "R6 resync overhead total", int'(oh_total), 12);
    check(ind_out == 1'b1, "R6 sync bit is overhead", int'(ind_out), 1);
    for (int i = 1; i < FRAME; i++) send_bit(next_bit(2'd0, i), 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    check(pay_total == 4704 && oh_total == 56, "R2 frame after resync", int'(pay_total), 4704);
    check(err_ind == 0 && err_data == 0, "R6 realigned positions", err_ind + err_data, 0);

    // R9: reset mid-frame, then first bit is position 0
    for (int i = 0; i < 40; i++) send_bit(1'b1, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #3;
    check({line_clk, ser_out, ind_out} == 3'b000 && pay_total == 0, "R9 async reset", int'({line_clk, ser_out, ind_out}), 0);
    model_reset();
    clear_errs();
    @(posedge clk); #2;
    rst_n = 1'b1;
    send_bit(1'b1, 1'b0, 1'b0);
    check(ind_out == 1'b1, "R9 first bit overhead", int'(ind_out), 1);
    for (int i = 1; i < 200; i++) send_bit(next_bit(2'd0, i), 1'b0, 1'b0);
    check(err_ind + err_lclk + err_data + err_tot == 0, "R9 restart alignment", err_ind + err_lclk + err_data + err_tot, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule